// File: doc/BRIEF.md
# Serial loss-of-signal detector

This block watches a bit-serial E3 receive stream and flags loss of signal. One data bit is presented per clock cycle in which the valid strobe is high; cycles with the strobe low carry no data and are ignored. The alarm is raised when a long unbroken run of zero bits arrives. It drops only after the line has shown a sustained stretch of bits with no short zero runs in it.

The declare and clear rules are deliberately different. The alarm rises after 32 consecutive zeros. To clear it, 32 received bits in a row must hold no run of four zeros. This gives hysteresis, so a marginal line does not toggle the alarm. The block drives the present alarm level for status reads. It also drives a one-cycle change pulse on every rising or falling transition of that level, for use by the interrupt logic.

Top module: `e3_los_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `los` and `los_chg` are 0, and all internal counts start from zero.
- R2: With `los` low, `los` goes high at the clock edge that samples the 32nd consecutive valid zero bit.
- R3: A valid 1 bit restarts the consecutive-zero count, so 31 zeros followed by a 1 never raise `los`.
- R4: With `los` high, `los` goes low at the clock edge that samples the 32nd valid bit after the last bit that completed a run of four zeros (or after the declaring bit).
- R5: While `los` is high, every valid zero that ends a run of four or more consecutive zeros restarts the clearing count. Zero runs of one to three bits do not restart it.
- R6: `los_chg` is high for exactly one cycle, in the cycle in which `los` first shows its new value, for each rising and each falling transition, and is low otherwise.
- R7: In cycles where `bit_vld` is 0, `bit_in` has no effect: no count advances and `los` does not change.
- R8: `los` is a level output that holds its value between transitions and can be read at any time as the current alarm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | High when `bit_in` carries a received bit |
| bit_in | input | 1 | Received data bit |
| los | output | 1 | Current loss-of-signal level |
| los_chg | output | 1 | One-cycle pulse on every change of `los` |

## Verification
The assertions take it as given that reset is applied at the start of the run. They also rely on inputs changing away from the rising edge, so each sampled valid bit is stable. The single-pulse property further assumes that declare and clear cannot occur in consecutive cycles. This follows from the 32-bit clearing window. The stimulus drives inputs only on the falling edge and starts with reset held for several cycles. It mixes long zero bursts, sparse-zero traffic and random invalid cycles, so both transitions occur many times within these limits.

// File: rtl/e3_los_monitor.sv
module e3_los_monitor #(
  parameter int DECLARE_LEN = 32,
  parameter int CLEAR_LEN   = 32,
  parameter int ZRUN_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic los,
  output logic los_chg
);
  localparam int ZW = $clog2(DECLARE_LEN + 1);
  localparam int CW = $clog2(CLEAR_LEN + 1);
  localparam logic [ZW-1:0] Z_MAX  = ZW'(DECLARE_LEN);
  localparam logic [ZW-1:0] Z_DECL = ZW'(DECLARE_LEN - 1);
  localparam logic [ZW-1:0] Z_RUN  = ZW'(ZRUN_LEN - 1);
  localparam logic [CW-1:0] C_LAST = CW'(CLEAR_LEN - 1);

  logic [ZW-1:0] zcnt;
  logic [CW-1:0] ccnt;
  logic          zero_in, run_done, declare, clear;

  assign zero_in  = bit_vld && !bit_in;
  assign run_done = zero_in && (zcnt >= Z_RUN);
  assign declare  = !los && zero_in && (zcnt == Z_DECL);
  assign clear    = los && bit_vld && !run_done && (ccnt == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt <= '0;
    end else if (bit_vld) begin
      if (bit_in)             zcnt <= '0;
      else if (zcnt != Z_MAX) zcnt <= zcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0;
    end else if (!los || clear || run_done) begin
      ccnt <= '0;
    end else if (bit_vld) begin
      ccnt <= ccnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los     <= 1'b0;
      los_chg <= 1'b0;
    end else begin
      los_chg <= declare || clear;
      if (declare)    los <= 1'b1;
      else if (clear) los <= 1'b0;
    end
  end
endmodule

// File: rtl/e3_los_monitor_chk.sv
module e3_los_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic bit_in,
  input logic los,
  input logic los_chg
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!los && !los_chg)); // R1
  AST_ONE_BLOCKS_DECLARE: assert property (@(posedge clk) disable iff (!rst_n)
    (!los && bit_vld && bit_in) |=> !los); // R3
  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (los != $past(los)) |-> los_chg); // R6
  AST_FLAG_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    los_chg |-> (los != $past(los))); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    los_chg |=> !los_chg); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(los)); // R7
endmodule

bind e3_los_monitor e3_los_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
  .los(los), .los_chg(los_chg)
);

// File: tb/e3_los_monitor_bench.sv
module e3_los_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic los, los_chg;
  int checks = 0, errors = 0;
  int m_z = 0, m_c = 0;
  bit m_los = 0, m_chg = 0;
  string tag = "R1";
  int seed = 17;

  always #2 clk = ~clk;

  e3_los_monitor u_e3_los_monitor (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .los(los), .los_chg(los_chg)
  );

  function automatic bit run_ends(int z, bit v, bit b);
    return v && !b && z >= 3;
  endfunction

  task automatic model(bit v, bit b);
    bit rd, clr;
    m_chg = 0;
    if (!v) return;
    rd  = run_ends(m_z, v, b);
    clr = 0;
    if (!m_los && !b && m_z == 31) begin m_los = 1; m_chg = 1; m_c = 0; end
    else if (m_los) begin
      if (rd) m_c = 0;
      else if (m_c == 31) begin m_los = 0; m_chg = 1; m_c = 0; clr = 1; end
      else m_c++;
    end
    if (b) m_z = 0; else if (m_z < 32) m_z++;
  endtask

  task automatic compare();
    checks++;
    if (los !== m_los || los_chg !== m_chg) begin
      errors++;
      $display("FAIL %s: los=%b los_chg=%b expected los=%b los_chg=%b at %0t",
               tag, los, los_chg, m_los, m_chg, $time);
    end
  endtask

  task automatic cyc(bit v, bit b);
    @(negedge clk);
    compare();
    bit_vld = v; bit_in = b;
    model(v, b);
  endtask

  task automatic zeros(int n); for (int i = 0; i < n; i++) cyc(1, 0); endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    cyc(0, 0); cyc(0, 0);
    tag = "R3"; zeros(31); cyc(1, 1); cyc(0, 0);
    tag = "R2"; zeros(31); cyc(1, 0); cyc(0, 0);
    tag = "R7"; for (int i = 0; i < 40; i++) cyc(0, 1'($urandom));
    tag = "R5"; for (int k = 0; k < 20; k++) begin cyc(1, 1); cyc(1, 0); cyc(1, 0); cyc(1, 0); end
    cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0);
    tag = "R4"; for (int i = 0; i < 31; i++) cyc(1, 1'(i % 3 != 0));
    cyc(1, 1); cyc(1, 1); cyc(1, 1);
    tag = "R6"; zeros(32); cyc(1, 1); cyc(1, 1);
    for (int i = 0; i < 32; i++) cyc(1, 1);
    tag = "R8";
    for (int blk = 0; blk < 300; blk++) begin
      int len = 20 + int'($urandom_range(0, 25));
      for (int i = 0; i < len; i++) cyc($urandom_range(0, 5) != 0, 1'b0);
      for (int i = 0; i < 60; i++)
        cyc($urandom_range(0, 5) != 0, $urandom_range(0, 3) != 0);
    end
    cyc(0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule